// File: doc/BRIEF.md
# Successive-Approximation Conversion Controller with Borrowed Output Ladder

This block sequences an 8-bit successive-approximation conversion that borrows the same resistor-ladder code path that normally drives a static analog output. A start pulse from the serial interface logic begins a conversion. The controller freezes both the input sample and the output buffer through two hold lines, and then tries the code bits one by one against an external comparator. The finished code goes into a result register, where it waits for transmission. After that the ladder goes back to the user's output code and both holds are released.

The controller is a four-state machine. IDLE forwards the user code to the ladder and waits for a start. WARM counts a fixed start-up delay when the clock-run enable is low. TRIAL runs one bit trial per clock, from the most significant bit down. DONE raises a one-cycle completion pulse. The transitions are:
- start-accept: IDLE to TRIAL, or IDLE to WARM when clock-run is low.
- warm-expire: WARM to TRIAL.
- last-trial: TRIAL to DONE.
- release: DONE to IDLE.

Differential conversions return two's complement and single-ended ones return offset binary. The comparator, the ladder and the buffer sit outside the block.

Top module: `sar_conv_ctrl`

## Requirements
- R1: When start_i is high at a clock edge in IDLE with clk_run_i high, done_o is high during the cycle that follows the ninth rising edge after that start edge. This is eight trials, one per clock, MSB first.
- R2: Trial bits are tried from bit 7 down to bit 0, and the first trial code on ladder_code_o is 0x80. A bit is kept when cmp_ge_i is high, meaning the input is greater than or equal to the ladder. A single-ended result equals the held input code in offset binary.
- R3: ladder_code_o equals user_code_i in every cycle that is not a trial cycle (idle, warm-up and done).
- R4: hold_in_o and hold_out_o are both high from the cycle after the start edge through the last trial. Both are low in the done cycle and in idle.
- R5: When diff_i is high at the start edge, result_o is the offset-binary trial code with bit 7 inverted, which is two's complement.
- R6: result_o changes only in the cycle in which done_o is high, and keeps its value at all other times.
- R7: done_o is high for exactly one cycle per conversion.
- R8: A start_i pulse that arrives while a conversion is running is ignored. Completion timing and result are those of the running conversion.
- R9: When clk_run_i is low at the start edge, WARMUP_CYCLES cycles (default 4) come before the first trial, so done_o appears 9+WARMUP_CYCLES edges after the start edge.
- R10: After reset, result_o is 0x80, done_o and both hold lines are low, and ladder_code_o follows user_code_i.
- R11: diff_i and clk_run_i are sampled only at the start edge. Changing them during a conversion has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion trigger pulse |
| diff_i | input | 1 | High selects a differential (two's complement) result |
| clk_run_i | input | 1 | High when the conversion clock is already running (no start-up wait) |
| cmp_ge_i | input | 1 | Comparator: held input is greater than or equal to the ladder voltage |
| user_code_i | input | 8 | Static analog output code |
| ladder_code_o | output | 8 | Code applied to the shared ladder |
| hold_in_o | output | 1 | Holds the input sample |
| hold_out_o | output | 1 | Holds the analog output buffer |
| result_o | output | 8 | Last conversion result |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach from the ports is a start pulse that lands in the middle of a conversion, combined with a change of the differential and clock-run inputs at that same moment. It must leave the timing and the coding of the running conversion untouched. The bench models the comparator and a sample-and-hold of the input behind hold_in_o. It raises start_i again and toggles diff_i and clk_run_i a few trials into a conversion, changes the analog input as well, and then checks the done latency and the result value. Codes at both rails and at mid-scale, in both codings, cover where the top bit flips.

// File: rtl/sar_pkg.sv
package sar_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WARM  = 2'd1,
        ST_TRIAL = 2'd2,
        ST_DONE  = 2'd3
    } sar_state_e;
endpackage

// File: rtl/sar_trial_reg.sv
module sar_trial_reg #(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    input  logic              cmp_ge,
    output logic [CODE_W-1:0] trial_code,
    output logic [CODE_W-1:0] kept_code,
    output logic              last
);
    localparam int IDX_W = (CODE_W > 1) ? $clog2(CODE_W) : 1;
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(CODE_W - 1);

    logic [CODE_W-1:0] acc_q;
    logic [IDX_W-1:0]  idx_q;
    logic [CODE_W-1:0] probe;

    // one-hot mask of the bit under trial
    for (genvar b = 0; b < CODE_W; b++) begin : g_probe
        assign probe[b] = (idx_q == IDX_W'(b));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            idx_q <= TOP_IDX;
        end else if (clear) begin
            acc_q <= '0;
            idx_q <= TOP_IDX;
        end else if (step) begin
            acc_q <= kept_code;
            if (idx_q != '0) begin
                idx_q <= idx_q - 1'b1;
            end
        end
    end

    always_comb begin
        trial_code = acc_q | probe;
        kept_code  = cmp_ge ? trial_code : acc_q;
        last       = (idx_q == '0);
    end
endmodule

// File: rtl/sar_warm_timer.sv
module sar_warm_timer #(
    parameter int WARMUP_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic tick,
    output logic expired
);
    localparam int CNT_W = $clog2(WARMUP_CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(WARMUP_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= LOAD_VAL;
        end else if (tick && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/sar_result_fmt.sv
module sar_result_fmt #(
    parameter int CODE_W = 8
) (
    input  logic              diff,
    input  logic [CODE_W-1:0] raw_code,
    output logic [CODE_W-1:0] coded
);
    // two's complement = offset binary with the sign bit flipped
    always_comb begin
        coded = raw_code;
        coded[CODE_W-1] = raw_code[CODE_W-1] ^ diff;
    end
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
    import sar_pkg::*;
#(
    parameter int CODE_W        = 8,
    parameter int WARMUP_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              diff_i,
    input  logic              clk_run_i,
    input  logic              cmp_ge_i,
    input  logic [CODE_W-1:0] user_code_i,
    output logic [CODE_W-1:0] ladder_code_o,
    output logic              hold_in_o,
    output logic              hold_out_o,
    output logic [CODE_W-1:0] result_o,
    output logic              done_o
);
    localparam logic [CODE_W-1:0] RESULT_RST = {1'b1, {(CODE_W-1){1'b0}}};

    sar_state_e        state_q, state_d;
    logic              diff_q;
    logic              start_accept;
    logic              warm_expired;
    logic              trial_last;
    logic [CODE_W-1:0] trial_code;
    logic [CODE_W-1:0] kept_code;
    logic [CODE_W-1:0] coded;
    logic [CODE_W-1:0] result_q;

    assign start_accept = (state_q == ST_IDLE) && start_i;

    sar_trial_reg #(.CODE_W(CODE_W)) u_trial (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (start_accept),
        .step       (state_q == ST_TRIAL),
        .cmp_ge     (cmp_ge_i),
        .trial_code (trial_code),
        .kept_code  (kept_code),
        .last       (trial_last)
    );

    sar_warm_timer #(.WARMUP_CYCLES(WARMUP_CYCLES)) u_warm (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (start_accept),
        .tick    (state_q == ST_WARM),
        .expired (warm_expired)
    );

    sar_result_fmt #(.CODE_W(CODE_W)) u_fmt (
        .diff     (diff_q),
        .raw_code (kept_code),
        .coded    (coded)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = clk_run_i ? ST_TRIAL : ST_WARM;
            ST_WARM:  if (warm_expired) state_d = ST_TRIAL;
            ST_TRIAL: if (trial_last) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
        endcase
    end

    // state register and sampled conversion mode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            diff_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (start_accept) begin
                diff_q <= diff_i;
            end
        end
    end

    // result register: loaded on the last trial edge only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_q <= RESULT_RST;
        end else if (state_q == ST_TRIAL && trial_last) begin
            result_q <= coded;
        end
    end

    // outputs
    always_comb begin
        ladder_code_o = user_code_i;
        hold_in_o     = 1'b0;
        hold_out_o    = 1'b0;
        done_o        = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_WARM: begin
                hold_in_o  = 1'b1;
                hold_out_o = 1'b1;
            end
            ST_TRIAL: begin
                hold_in_o     = 1'b1;
                hold_out_o    = 1'b1;
                ladder_code_o = trial_code;
            end
            ST_DONE: done_o = 1'b1;
        endcase
    end

    assign result_o = result_q;
endmodule

// File: rtl/sar_conv_ctrl_chk.sv
module sar_conv_ctrl_chk #(
    parameter int CODE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CODE_W-1:0] user_code_i,
    input logic [CODE_W-1:0] ladder_code_o,
    input logic              hold_out_o,
    input logic [CODE_W-1:0] result_o,
    input logic              done_o
);
    // R7: completion pulse lasts one cycle
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6: result moves only with done
    a_r6_result_only_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result_o) |-> done_o);

    // R3: ladder follows the user code outside the hold window
    a_r3_ladder_user: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_out_o |-> (ladder_code_o == user_code_i));

    // R4: holds drop exactly into the done cycle
    a_r4_release_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_out_o) |-> done_o);

    // R4: done never overlaps the hold window
    a_r4_no_hold_in_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !hold_out_o);
endmodule

bind sar_conv_ctrl sar_conv_ctrl_chk #(.CODE_W(CODE_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .user_code_i   (user_code_i),
    .ladder_code_o (ladder_code_o),
    .hold_out_o    (hold_out_o),
    .result_o      (result_o),
    .done_o        (done_o)
);

// File: tb/sar_conv_ctrl_tb_top.sv
`timescale 1ns/1ps
module sar_conv_ctrl_tb_top;
    localparam int W    = 4;  // warm-up cycles, default of the design
    localparam int NVEC = 9;
    // {vin[17:10], diff[9], clk_run[8], expected[7:0]}
    localparam logic [17:0] VEC [NVEC] = '{
        {8'h00, 1'b0, 1'b1, 8'h00},
        {8'hFF, 1'b0, 1'b1, 8'hFF},
        {8'hC3, 1'b0, 1'b1, 8'hC3},
        {8'h80, 1'b1, 1'b1, 8'h00},
        {8'h7F, 1'b1, 1'b1, 8'hFF},
        {8'h00, 1'b1, 1'b1, 8'h80},
        {8'hFF, 1'b1, 1'b1, 8'h7F},
        {8'h5A, 1'b0, 1'b0, 8'h5A},
        {8'hA5, 1'b1, 1'b0, 8'h25}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       diff_i = 1'b0;
    logic       clk_run_i = 1'b1;
    logic [7:0] user_code_i = 8'h3C;
    logic [7:0] ladder_code_o;
    logic       hold_in_o, hold_out_o, done_o;
    logic [7:0] result_o;
    logic [7:0] vin = 8'h00;
    logic [7:0] vin_held = 8'h00;
    logic       cmp_ge_i;
    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    // analog model: sample-and-hold plus comparator
    always @(posedge clk) if (!hold_in_o) vin_held <= vin;
    assign cmp_ge_i = (vin_held >= ladder_code_o);

    sar_conv_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .diff_i(diff_i),
        .clk_run_i(clk_run_i), .cmp_ge_i(cmp_ge_i), .user_code_i(user_code_i),
        .ladder_code_o(ladder_code_o), .hold_in_o(hold_in_o), .hold_out_o(hold_out_o),
        .result_o(result_o), .done_o(done_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // runs one conversion; mid_poke re-triggers and flips mode inputs at cycle 3
    task automatic run_conv(input logic [7:0] v, input logic d, input logic cr,
                            input logic [7:0] exp, input bit mid_poke);
        int lat;
        int n;
        bit holds_ok;
        lat = cr ? 9 : 9 + W;
        @(negedge clk);
        vin = v; diff_i = d; clk_run_i = cr; start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        n = 1;
        holds_ok = 1'b1;
        if (cr) check("R2 first trial code", ladder_code_o, 8'h80);
        else check("R3 ladder during warm-up", ladder_code_o, user_code_i);
        while (!done_o && n < 60) begin
            if (!(hold_in_o && hold_out_o)) holds_ok = 1'b0;
            if (mid_poke && n == 3) begin
                start_i = 1'b1; diff_i = ~d; clk_run_i = ~cr; vin = ~v;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        start_i = 1'b0;
        check("R1/R9 done latency", n, lat);
        check("R4 holds high during conversion", holds_ok, 1);
        check("R4 holds low at done", {hold_in_o, hold_out_o}, 0);
        check(d ? "R5 differential result" : "R2 single-ended result", result_o, exp);
        @(negedge clk);
        check("R7 done one cycle", done_o, 0);
        if (mid_poke) check("R8 no restart after ignored start", hold_out_o, 0);
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 result after reset", result_o, 8'h80);
        check("R10 done after reset", done_o, 0);
        check("R10 holds after reset", {hold_in_o, hold_out_o}, 0);
        check("R10 ladder after reset", ladder_code_o, user_code_i);
        rst_n = 1'b1;
        @(negedge clk);
        user_code_i = 8'hE1;
        #1;
        check("R3 ladder follows user code in idle", ladder_code_o, 8'hE1);

        for (int i = 0; i < NVEC; i++) begin
            run_conv(VEC[i][17:10], VEC[i][9], VEC[i][8], VEC[i][7:0], 1'b0);
        end

        // R8 and R11: retrigger and flipped modes mid conversion
        run_conv(8'h96, 1'b0, 1'b1, 8'h96, 1'b1);
        run_conv(8'h31, 1'b1, 1'b0, 8'hB1, 1'b1);

        // R6: result holds in idle while the input moves
        vin = 8'h11;
        repeat (6) @(negedge clk);
        check("R6 result held in idle", result_o, 8'hB1);
        check("R3 ladder after conversion", ladder_code_o, 8'hE1);

        // R10: reset mid-conversion restores reset result
        run_conv(8'h44, 1'b0, 1'b1, 8'h44, 1'b0);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 result after second reset", result_o, 8'h80);
        check("R10 holds after second reset", hold_out_o, 0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule